// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Sequencer

This block is a clocked front end for a 256K-word by 16-bit asynchronous static RAM. A host presents one request at a time: an address, a write-data word, a read/write flag and a two-bit lane mask. The block accepts it when `req_ready` is high. It then drives the memory's active-low select, write, output-enable and per-lane enable strobes for a fixed number of clock cycles, and hands read data back with a one-cycle `rsp_valid` pulse. No clocking or refresh reaches the memory. Every timing margin comes from whole system-clock cycles, set by parameters.

Writes are controlled by the write strobe, and output enable stays high for the whole write, so the short write-pulse rule applies. The block's own data drivers turn on only one cycle after the write strobe has fallen. They stay on for one cycle after it rises, which gives positive data hold. When a write follows a read, one quiet cycle with every strobe deasserted is inserted first, so the memory's outputs can float before the block drives the shared bus. The tri-state bus is presented as a split output/enable/input triple, and the pad is left to the chip level.

Top module: `asram_bridge`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0, `mem_dq_oe` is 0, and `mem_cs_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are 1.
- R2: An accepted read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles. `rsp_valid` is high for exactly one cycle, in the cycle after that window, and carries data sampled on the window's last cycle.
- R3: Lane mask bit 0 governs bits 7..0 and bit 1 governs bits 15..8. During a cycle `mem_be_n[i]` equals the inverse of mask bit i. `rsp_rdata` lanes whose mask bit is 0 read as zero, whatever the memory presents on them.
- R4: An accepted write holds `mem_cs_n`=0 and `mem_we_n`=0 for exactly WR_CYC cycles, with `mem_oe_n`=1 for the entire write.
- R5: `mem_dq_oe` is 0 in the first cycle of the write window and 1 from its second cycle. It stays 1 with `mem_dq_out` equal to the write data for one further cycle after `mem_we_n` returns to 1 (select still low), then drops to 0.
- R6: A write accepted after a completed read starts with one cycle in which all strobes are deasserted. A write after a write starts its write window at once.
- R7: `mem_addr` and `mem_be_n` do not change while `mem_cs_n` stays low.
- R8: `mem_dq_oe` and a low `mem_oe_n` are never present together.
- R9: `req_ready` is 0 in every cycle that `mem_cs_n` is low or a turnaround is running, and returns to 1 once the access ends.
- R10: With an all-zero lane mask, a cycle still runs with both `mem_be_n` bits high. A write then changes no stored data, and a read returns zero.
- R11: A write stores only the lanes selected by its mask. Unselected lanes keep their earlier contents, which a later full read shows.
- R12: Consecutive reads insert no turnaround: the second read's select falls in the cycle after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | LANES | Lane mask, bit i selects byte i |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | LANES | Per-lane enables, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the block's data drivers |
| mem_dq_in | input | DATA_W | Data returned from the memory |

## Verification
Two events can fall in the same cycle. The end of a read, where data is captured, `rsp_valid` rises and the turnaround flag is set, can coincide with the decision for a write that follows it. That decision must route through the quiet cycle and not drive the bus early. The bench provokes this by issuing writes straight after reads across a full address sweep. It judges each cycle by comparing the strobe vector and `mem_dq_oe` with the sequence worked out from R5 and R6. The same sweep checks that reads stored in the bench's memory model return the lanes written under every mask pattern.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WREC  = 3'd4
  } seq_state_t;

  // True on the final cycle of a window that lasts len cycles.
  function automatic logic window_end(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  // Widest window among read and write, used to size the counter.
  function automatic int unsigned max_window(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_CYC = 2   // must be at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic sel,
  output logic we_act,
  output logic oe_act,
  output logic rd_capture,
  output logic drive_on
);

  localparam int unsigned MAXC  = max_window(RD_CYC, WR_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             after_rd_q, after_rd_d;
  logic             rd_last, wr_last;

  assign rd_last = window_end(int'(cnt_q), RD_CYC);
  assign wr_last = window_end(int'(cnt_q), WR_CYC);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    after_rd_d = after_rd_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cnt_d = '0;
          if (req_write) st_d = after_rd_q ? ST_TURN : ST_WRITE;
          else           st_d = ST_READ;
        end
      end
      ST_TURN: begin
        st_d  = ST_WRITE;
        cnt_d = '0;
      end
      ST_READ: begin
        if (rd_last) begin
          st_d       = ST_IDLE;
          cnt_d      = '0;
          after_rd_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WRITE: begin
        if (wr_last) begin
          st_d  = ST_WREC;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WREC: begin
        st_d       = ST_IDLE;
        after_rd_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      after_rd_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      after_rd_q <= after_rd_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign sel        = (st_q == ST_READ) || (st_q == ST_WRITE) || (st_q == ST_WREC);
  assign we_act     = (st_q == ST_WRITE);
  assign oe_act     = (st_q == ST_READ);
  assign rd_capture = (st_q == ST_READ) && rd_last;
  assign drive_on   = ((st_q == ST_WRITE) && (cnt_q != '0)) || (st_q == ST_WREC);

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W/LANE_W-1:0]   req_be,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       sel,
  input  logic                       rd_capture,
  input  logic [DATA_W-1:0]          mem_dq_in,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W/LANE_W-1:0]   mem_be_n,
  output logic [DATA_W-1:0]          mem_dq_out,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rd_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_be_n[g] = ~(sel && be_q[g]);
    assign rd_masked[g*LANE_W +: LANE_W] =
      be_q[g] ? mem_dq_in[g*LANE_W +: LANE_W] : {LANE_W{1'b0}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_capture;
      if (rd_capture) rdata_q <= rd_masked;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W/LANE_W-1:0] req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_cs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [DATA_W/LANE_W-1:0] mem_be_n,
  output logic [DATA_W-1:0]        mem_dq_out,
  output logic                     mem_dq_oe,
  input  logic [DATA_W-1:0]        mem_dq_in
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  // Named internal events, also observed by the bound checker.
  logic accept;
  logic sel;
  logic we_act;
  logic oe_act;
  logic rd_capture;
  logic drive_on;

  asram_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .accept     (accept),
    .sel        (sel),
    .we_act     (we_act),
    .oe_act     (oe_act),
    .rd_capture (rd_capture),
    .drive_on   (drive_on)
  );

  asram_lanes #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .sel        (sel),
    .rd_capture (rd_capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign mem_cs_n  = ~sel;
  assign mem_we_n  = ~we_act;
  assign mem_oe_n  = ~oe_act;
  assign mem_dq_oe = drive_on;

endmodule

// File: rtl/asram_bridge_chk.sv
module asram_bridge_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be_n,
  input logic              rd_capture
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2
  capture_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R5
  drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(!mem_we_n));

  // R5
  hold_past_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_cs_n) |-> mem_dq_oe);

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n, 1) && $past(mem_oe_n, 2)));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

endmodule

bind asram_bridge asram_bridge_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_be_n   (mem_be_n),
  .rd_capture (rd_capture)
);

// File: tb/asram_bridge_tb.sv
`timescale 1ns/1ps
module asram_bridge_tb;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int RD = 2;
  localparam int WR = 2;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int n_checks = 0;
  int n_err = 0;
  bit last_rd = 1'b0;

  logic [DW-1:0] sram    [WORDS];
  logic [DW-1:0] exp_mem [WORDS];
  logic          prev_we = 1'b1;

  always #2 clk = ~clk;

  asram_bridge #(
    .ADDR_W (AW), .DATA_W (DW), .LANE_W (8), .RD_CYC (RD), .WR_CYC (WR)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_addr (req_addr), .req_be (req_be),
    .req_wdata (req_wdata), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_be_n (mem_be_n), .mem_dq_out (mem_dq_out),
    .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  // Memory model: drives only enabled lanes during a read, filler elsewhere.
  always_comb begin
    for (int i = 0; i < 2; i++) begin
      mem_dq_in[i*8 +: 8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_be_n[i])
                            ? sram[mem_addr][i*8 +: 8] : 8'hA5;
    end
  end

  // Store enabled lanes when the write strobe rises.
  always @(negedge clk) begin
    prev_we <= mem_we_n;
    if (!prev_we && mem_we_n && !mem_cs_n && mem_dq_oe) begin
      for (int i = 0; i < 2; i++)
        if (!mem_be_n[i]) sram[mem_addr][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_be_n};
  endfunction

  localparam logic [5:0] IDLE_S = 6'b111011;

  function automatic logic [DW-1:0] lane_pick(input logic [DW-1:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] be);
    logic [5:0] e;
    @(negedge clk);
    check(req_ready, "R9 ready before read", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be; req_wdata = 16'h5A5A;
    @(negedge clk);
    req_valid = 1'b0;
    e = {1'b0, 1'b1, 1'b0, 1'b0, ~be};
    for (int k = 0; k < RD; k++) begin
      // R12: select falls in the first cycle after acceptance, no turnaround
      check(strobes() == e, "R2 R3 R12 read strobes", strobes(), e);
      check(mem_addr == a, "R7 read address", mem_addr, a);
      check(!req_ready, "R9 busy during read", req_ready, 0);
      if (k < RD - 1) @(negedge clk);
    end
    @(negedge clk);
    check(rsp_valid, "R2 rsp_valid pulse", rsp_valid, 1);
    check(rsp_rdata == lane_pick(exp_mem[a], be), "R3 R10 R11 read data",
          rsp_rdata, lane_pick(exp_mem[a], be));
    check(strobes() == IDLE_S && req_ready, "R9 idle after read", strobes(), IDLE_S);
    @(negedge clk);
    check(!rsp_valid, "R2 rsp_valid one cycle", rsp_valid, 0);
    last_rd = 1'b1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    logic [5:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (last_rd) begin
      check(strobes() == IDLE_S, "R6 turnaround cycle", strobes(), IDLE_S);
      check(!req_ready, "R9 busy in turnaround", req_ready, 0);
      @(negedge clk);
    end
    for (int k = 0; k < WR; k++) begin
      e = {1'b0, 1'b0, 1'b1, (k != 0), ~be};
      check(strobes() == e, "R4 R5 R6 write strobes", strobes(), e);
      check(mem_addr == a, "R7 write address", mem_addr, a);
      if (k != 0) check(mem_dq_out == d, "R5 write data driven", mem_dq_out, d);
      @(negedge clk);
    end
    e = {1'b0, 1'b1, 1'b1, 1'b1, ~be};
    check(strobes() == e, "R5 hold after write strobe", strobes(), e);
    check(mem_dq_out == d, "R5 data held", mem_dq_out, d);
    @(negedge clk);
    check(strobes() == IDLE_S, "R5 drivers released", strobes(), IDLE_S);
    for (int i = 0; i < 2; i++)
      if (be[i]) exp_mem[a][i*8 +: 8] = d[i*8 +: 8];
    last_rd = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      sram[i] = '0;
      exp_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(strobes() == IDLE_S, "R1 strobes in reset", strobes(), IDLE_S);
    check(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(strobes() == IDLE_S && req_ready, "R1 after reset", strobes(), IDLE_S);

    // Full-word fill; write follows write (R6 no turnaround).
    for (int a = 0; a < WORDS; a++)
      do_write(AW'(a), DW'(a * 16'h1357 + 16'h2468), 2'b11);
    // Every address under every mask (R3, R10, R12).
    for (int a = 0; a < WORDS; a++)
      for (int m = 0; m < 4; m++)
        do_read(AW'(a), 2'(m));
    // Lane-selective writes after reads (R6, R10, R11).
    for (int a = 0; a < WORDS; a++) begin
      do_write(AW'(a), DW'(a * 16'h0F1D + 16'hC001), 2'b01);
      do_read(AW'(a), 2'b11);
      do_write(AW'(a), DW'(a * 16'h3B07 + 16'h7E00), 2'b10);
      do_write(AW'(a), 16'hFFFF, 2'b00);
      do_read(AW'(a), 2'b11);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule